// File: doc/BRIEF.md
# Multi-Trigger Conversion Sequencer

This block drives an external successive-approximation converter through a short start/done handshake and decides when and in which order channels are sampled. Software keeps a channel mask by writing ones into a set register and a clear register, and reads the resulting mask back. A sequence starts on a software start, or on one hardware source chosen from five: an external pin edge, a pen-detect pulse, free-running back-to-back sequences, a programmable period timer, or a peripheral event pulse.

When a sequence starts, the block can first wake the converter and wait a fixed startup time. It then converts every selected channel from the lowest index upward, and puts the converter back into low power after the last result. Each result, tagged with its channel number, overwrites one shared result register and sets a ready flag. When transfers are enabled, each result also raises a one-cycle transfer request. In touch mode, four consecutive channels starting at a programmable base are added to the sequence. They are converted in ascending order together with the other enabled channels.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Writing a word with bit 0 set to address 0 starts a sequence. This software start works whichever hardware source is selected.
- R2: Configuration (address 1) has these fields:
  - bit 0: sleep enable
  - bit 1: touch mode
  - bit 2: transfer enable
  - bits 5:3: trigger source (0 none, 1 pin, 2 pen pulse, 3 continuous, 4 periodic, 5 peripheral event)
  - bits 7:6: pin edge
  - bits 11:8: touch base

  Only the selected hardware source starts sequences.
- R3: The pin input passes through two synchronizing flops and is then edge detected. Edge code 0 fires on a rising edge, 1 on a falling edge, and 2 or 3 on any edge.
- R4: In periodic mode, a down-counter reloads from the period register (address 5) when it reaches zero. A trigger fires every period+1 cycles.
- R5: In continuous mode, a new sequence starts as soon as the previous one ends.
- R6: Writing ones to address 2 sets mask bits, and writing ones to address 3 clears them. Address 4 reads back the mask.
- R7: Enabled channels are converted in ascending index order. One conv_start pulse is issued per channel.
- R8: In touch mode, channels base to base+3 are converted in addition to the mask, in ascending order together with the other channels.
- R9: With sleep enabled, adc_sleep is high while idle. It drops when a sequence starts, stays low for at least 4 cycles before the first conversion, and is raised again after the last conversion. No conversion starts while adc_sleep is high.
- R10: Reading address 6 returns data in bits 9:0, the channel in bits 13:10 and the valid flag in bit 31. The valid flag is set by every result and cleared by a read.
- R11: With transfers enabled, dma_req pulses once per result. With transfers disabled, it never pulses.
- R12: Triggers that arrive during a sequence are ignored. A trigger with an empty channel set starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe (clears result flag at address 6) |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data |
| ext_trig | input | 1 | Asynchronous trigger pin |
| pen_evt | input | 1 | Pen-detect pulse |
| periph_evt | input | 1 | Peripheral event pulse |
| conv_start | output | 1 | One-cycle converter start |
| conv_chan | output | 4 | Channel being converted |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 10 | Converter result |
| adc_sleep | output | 1 | Converter low-power request |
| busy | output | 1 | Sequence in progress |
| result_ready | output | 1 | Result register holds an unread value |
| dma_req | output | 1 | One-cycle transfer request per result |

## Verification
The main function is tried with several patterns:
- A sparse mask under a software start, which separates ascending order from any other order.
- A mask that surrounds the touch group, which shows whether the group is merged in index order or appended.
- Trigger sources selected in turn while pulses are sent on the unselected inputs. This shows that only the chosen source acts.
- Pin toggles under each edge setting, which tell rising, falling and any-edge detection apart.
- A repeated start during a sequence and a start with an empty mask, which show that both are ignored.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int NCH = 16,
  parameter int DW = 10,
  parameter int PW = 16,
  parameter int STARTUP = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           rd_en,
  input  logic [2:0]     rd_addr,
  output logic [31:0]    rd_data,
  input  logic           ext_trig,
  input  logic           pen_evt,
  input  logic           periph_evt,
  output logic           conv_start,
  output logic [CHW-1:0] conv_chan,
  input  logic           conv_done,
  input  logic [DW-1:0]  conv_data,
  output logic           adc_sleep,
  output logic           busy,
  output logic           result_ready,
  output logic           dma_req
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_SET = 3'd2, A_CLR = 3'd3,
                         A_STAT = 3'd4, A_PER = 3'd5, A_RES = 3'd6;
  localparam int SW = $clog2(STARTUP + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_SCAN, S_WAIT} state_t;
  state_t state;

  logic [NCH-1:0] mask, rem, eff_mask, touch_mask;
  logic           sleep_en, touch_en, dma_en;
  logic [2:0]     src;
  logic [1:0]     edge_sel;
  logic [CHW-1:0] tbase, nxt;
  logic [PW-1:0]  period, pcnt;
  logic [SW-1:0]  wcnt;
  logic [2:0]     sync;
  logic [DW-1:0]  res_data;
  logic [CHW-1:0] res_ch;
  logic           res_valid;
  logic           pin_rise, pin_fall, pin_hit, hw_trig, sw_trig;

  assign touch_mask = touch_en ? (NCH'(4'hF) << tbase) : '0;
  assign eff_mask   = mask | touch_mask;
  assign sw_trig    = wr_en && wr_addr == A_CTRL && wr_data[0];
  assign pin_rise   = sync[1] && !sync[2];
  assign pin_fall   = !sync[1] && sync[2];
  assign pin_hit    = edge_sel == 2'd0 ? pin_rise :
                      edge_sel == 2'd1 ? pin_fall : (pin_rise || pin_fall);

  always_comb begin
    case (src)
      3'd1:    hw_trig = pin_hit;
      3'd2:    hw_trig = pen_evt;
      3'd3:    hw_trig = 1'b1;
      3'd4:    hw_trig = pcnt == '0;
      3'd5:    hw_trig = periph_evt;
      default: hw_trig = 1'b0;
    endcase
  end

  always_comb begin
    nxt = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (rem[i]) nxt = CHW'(i);
  end

  assign busy         = state != S_IDLE;
  assign adc_sleep    = sleep_en && state == S_IDLE;
  assign result_ready = res_valid;

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = 32'({tbase, edge_sel, src, dma_en, touch_en, sleep_en});
      A_STAT:  rd_data = 32'(mask);
      A_PER:   rd_data = 32'(period);
      A_RES:   rd_data = {res_valid, 31'(DW'(0)) | 31'({res_ch, res_data})};
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; mask <= '0; rem <= '0; sleep_en <= 1'b0; touch_en <= 1'b0;
      dma_en <= 1'b0; src <= '0; edge_sel <= '0; tbase <= '0; period <= '0;
      pcnt <= '0; wcnt <= '0; sync <= '0; res_data <= '0; res_ch <= '0;
      res_valid <= 1'b0; conv_start <= 1'b0; conv_chan <= '0; dma_req <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      dma_req    <= 1'b0;
      sync       <= {sync[1:0], ext_trig};
      if (wr_en) begin
        case (wr_addr)
          A_CFG: begin
            sleep_en <= wr_data[0]; touch_en <= wr_data[1]; dma_en <= wr_data[2];
            src <= wr_data[5:3]; edge_sel <= wr_data[7:6]; tbase <= wr_data[8 +: CHW];
          end
          A_SET:   mask <= mask | wr_data[NCH-1:0];
          A_CLR:   mask <= mask & ~wr_data[NCH-1:0];
          A_PER:   period <= wr_data[PW-1:0];
          default: ;
        endcase
      end
      if (src == 3'd4) pcnt <= (pcnt == '0) ? period : pcnt - 1'b1;
      else             pcnt <= period;
      if (rd_en && rd_addr == A_RES) res_valid <= 1'b0;
      case (state)
        S_IDLE:
          if ((sw_trig || hw_trig) && eff_mask != '0) begin
            rem   <= eff_mask;
            wcnt  <= SW'(STARTUP - 1);
            state <= sleep_en ? S_WAKE : S_SCAN;
          end
        S_WAKE:
          if (wcnt == '0) state <= S_SCAN;
          else            wcnt  <= wcnt - 1'b1;
        S_SCAN:
          if (rem == '0) state <= S_IDLE;
          else begin
            conv_start <= 1'b1;
            conv_chan  <= nxt;
            rem[nxt]   <= 1'b0;
            state      <= S_WAIT;
          end
        S_WAIT:
          if (conv_done) begin
            res_data  <= conv_data;
            res_ch    <= conv_chan;
            res_valid <= 1'b1;
            dma_req   <= dma_en;
            state     <= S_SCAN;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_START_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !adc_sleep); // R9
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R7
  AST_REQ_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> result_ready); // R11
  AST_VALID_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(conv_done)); // R10
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SET) |=> ((mask & $past(wr_data[NCH-1:0])) == $past(wr_data[NCH-1:0]))); // R6
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) |=> ((mask & $past(wr_data[NCH-1:0])) == '0)); // R6
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, ext_trig = 0, pen_evt = 0, periph_evt = 0, conv_done = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic conv_start, adc_sleep, busy, result_ready, dma_req;
  logic [3:0] conv_chan;
  logic [9:0] conv_data = 0;
  int n_chk = 0, n_bad = 0;
  int order[64];
  int n_order = 0, n_dma = 0, n_seq = 0, sleep_viol = 0;
  int cyc = 0, t_wake = -1, t_first = -1;
  logic busy_q = 0, sleep_q = 0;
  int mcnt = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl uut (.*);

  function automatic logic [9:0] model(input logic [3:0] ch);
    return 10'(ch * 37 + 5);
  endfunction

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (mcnt != 0) begin
      mcnt <= mcnt - 1;
      if (mcnt == 1) conv_done <= 1'b1;
    end
    if (conv_start) begin
      mcnt <= 3;
      conv_data <= model(conv_chan);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (conv_start) begin
      if (n_order < 64) order[n_order] = int'(conv_chan);
      n_order++;
      if (adc_sleep) sleep_viol++;
      if (t_first < 0) t_first = cyc;
    end
    if (dma_req) n_dma++;
    if (busy && !busy_q) n_seq++;
    if (!adc_sleep && sleep_q && t_wake < 0) t_wake = cyc;
    busy_q = busy;
    sleep_q = adc_sleep;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic clr, output logic [31:0] d);
    @(negedge clk); rd_addr = a; rd_en = clr; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  function automatic logic [31:0] cfg(input int sl, input int tm, input int dm,
                                      input int sr, input int ed, input int tb);
    return 32'(sl | (tm << 1) | (dm << 2) | (sr << 3) | (ed << 6) | (tb << 8));
  endfunction

  task automatic clear_log();
    n_order = 0; n_dma = 0; n_seq = 0; sleep_viol = 0; t_wake = -1; t_first = -1;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(busy == 0 && adc_sleep == 0 && result_ready == 0 && dma_req == 0, "R12 reset idle", busy, 0);
    rd(3'd4, 0, d); chk(d == 0, "R6 reset mask", d, 0);
    rd(3'd6, 0, d); chk(d[31] == 0, "R10 reset valid", d[31], 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(3'd2, 32'h00A5); wr(3'd3, 32'h0005);
    rd(3'd4, 0, d); chk(d == 32'h00A0, "R6 set/clear", d, 32'hA0);
    wr(3'd3, 32'hFFFF);
    rd(3'd4, 0, d); chk(d == 0, "R6 clear all", d, 0);
  endtask

  task automatic t_order_result();
    logic [31:0] d;
    wr(3'd1, cfg(0, 0, 0, 0, 0, 0));
    wr(3'd2, 32'h0000_008A);
    clear_log();
    wr(3'd0, 1); wait_idle();
    chk(n_order == 3, "R7 count", n_order, 3);
    chk(order[0] == 1 && order[1] == 3 && order[2] == 7, "R7 order", order[0]*100 + order[1]*10 + order[2], 137);
    chk(n_dma == 0, "R11 no request when disabled", n_dma, 0);
    chk(result_ready == 1, "R10 ready", result_ready, 1);
    rd(3'd6, 1, d);
    chk(d[9:0] == model(7), "R10 data", d[9:0], model(7));
    chk(d[13:10] == 7 && d[31] == 1, "R10 chan/valid", d[13:10], 7);
    rd(3'd6, 0, d);
    chk(d[31] == 0 && result_ready == 0, "R10 clear on read", d[31], 0);
  endtask

  task automatic t_dma();
    wr(3'd1, cfg(0, 0, 1, 0, 0, 0));
    clear_log(); wr(3'd0, 1); wait_idle();
    chk(n_dma == 3, "R11 request per result", n_dma, 3);
  endtask

  task automatic t_busy_ignore();
    wr(3'd1, cfg(0, 0, 0, 0, 0, 0));
    clear_log(); wr(3'd0, 1); wr(3'd0, 1); wait_idle();
    chk(n_seq == 1 && n_order == 3, "R12 start while busy ignored", n_seq, 1);
  endtask

  task automatic t_empty();
    wr(3'd3, 32'hFFFF);
    clear_log(); wr(3'd0, 1); repeat (20) @(negedge clk);
    chk(n_order == 0 && n_seq == 0, "R12 empty mask", n_order, 0);
  endtask

  task automatic t_sleep();
    wr(3'd2, 32'h0002);
    wr(3'd1, cfg(1, 0, 0, 0, 0, 0));
    @(negedge clk); chk(adc_sleep == 1, "R9 idle asleep", adc_sleep, 1);
    clear_log(); wr(3'd0, 1); wait_idle();
    chk(sleep_viol == 0 && n_order == 1, "R9 awake during conversion", sleep_viol, 0);
    chk(t_wake > 0 && t_first - t_wake >= 4, "R9 startup wait", t_first - t_wake, 4);
    chk(adc_sleep == 1, "R9 asleep after sequence", adc_sleep, 1);
  endtask

  task automatic t_touch();
    wr(3'd3, 32'hFFFF); wr(3'd2, 32'h1005);
    wr(3'd1, cfg(0, 1, 0, 0, 0, 4));
    clear_log(); wr(3'd0, 1); wait_idle();
    chk(n_order == 7, "R8 count", n_order, 7);
    chk(order[0] == 0 && order[1] == 2 && order[2] == 4 && order[3] == 5 &&
        order[4] == 6 && order[5] == 7 && order[6] == 12, "R8 order", order[6], 12);
  endtask

  task automatic t_pin();
    wr(3'd3, 32'hFFFF); wr(3'd2, 32'h0004);
    wr(3'd1, cfg(0, 0, 0, 1, 0, 0));
    clear_log();
    @(negedge clk) ext_trig = 1; wait_idle();
    @(negedge clk) ext_trig = 0; wait_idle();
    chk(n_seq == 1, "R3 rising", n_seq, 1);
    wr(3'd1, cfg(0, 0, 0, 1, 1, 0)); clear_log();
    @(negedge clk) ext_trig = 1; wait_idle();
    @(negedge clk) ext_trig = 0; wait_idle();
    chk(n_seq == 1, "R3 falling", n_seq, 1);
    wr(3'd1, cfg(0, 0, 0, 1, 2, 0)); clear_log();
    @(negedge clk) ext_trig = 1; wait_idle();
    @(negedge clk) ext_trig = 0; wait_idle();
    chk(n_seq == 2, "R3 any edge", n_seq, 2);
    clear_log(); wr(3'd0, 1); wait_idle();
    chk(n_seq == 1, "R1 software start with pin selected", n_seq, 1);
  endtask

  task automatic t_pulses();
    wr(3'd1, cfg(0, 0, 0, 2, 0, 0)); clear_log();
    @(negedge clk) periph_evt = 1; @(negedge clk) periph_evt = 0; wait_idle();
    chk(n_seq == 0, "R2 unselected event ignored", n_seq, 0);
    @(negedge clk) pen_evt = 1; @(negedge clk) pen_evt = 0; wait_idle();
    chk(n_seq == 1, "R2 pen trigger", n_seq, 1);
    wr(3'd1, cfg(0, 0, 0, 5, 0, 0)); clear_log();
    @(negedge clk) pen_evt = 1; @(negedge clk) pen_evt = 0; wait_idle();
    @(negedge clk) periph_evt = 1; @(negedge clk) periph_evt = 0; wait_idle();
    chk(n_seq == 1, "R2 peripheral event trigger", n_seq, 1);
  endtask

  task automatic t_periodic();
    wr(3'd5, 20);
    clear_log();
    wr(3'd1, cfg(0, 0, 0, 4, 0, 0));
    repeat (210) @(negedge clk);
    wr(3'd1, cfg(0, 0, 0, 0, 0, 0)); wait_idle();
    chk(n_seq >= 9 && n_seq <= 11, "R4 periodic rate", n_seq, 10);
  endtask

  task automatic t_cont();
    clear_log();
    wr(3'd1, cfg(0, 0, 0, 3, 0, 0));
    repeat (100) @(negedge clk);
    wr(3'd1, cfg(0, 0, 0, 0, 0, 0)); wait_idle();
    chk(n_seq >= 10, "R5 continuous restarts", n_seq, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_order_result();
    t_dma();
    t_busy_ignore();
    t_empty();
    t_sleep();
    t_touch();
    t_pin();
    t_pulses();
    t_periodic();
    t_cont();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule